// File: doc/BRIEF.md
# Byte-Range Cache Maintenance Splitter

This block sits between a requester that issues cache maintenance over an arbitrary byte range and a range engine that can only work on whole cache lines inside one page. A request carries a start address, an end address that is one past the last byte, an operation kind (invalidate, clean or flush) and a write-through override flag. The block aligns the range to cache lines and splits it into chunks. It emits those chunks one at a time as commands. Each command carries an opcode, the address of its first line and the address of its last line, so both ends are inclusive.

Invalidate must not discard dirty bytes outside the requested range. A partial line at either edge of an invalidate request therefore gets a single-line clean-and-invalidate instead of being included in a range invalidate. Clean and flush widen the range outward to whole lines. When the cache runs in write-through override mode, clean work is redundant: a clean request produces no commands, and a flush sends only the invalidates.

Commands leave in ascending address order. A request is taken only while the block is idle. The block pulses `done` one cycle after the engine accepts the last command of that request.

Top module: `range_splitter`

## Requirements
- R1: Every command's `cmd_lo` and `cmd_hi` are line aligned (low log2(LINE_BYTES) bits zero). For a range command, `cmd_hi` is the exclusive chunk end minus LINE_BYTES, so `cmd_hi >= cmd_lo`.
- R2: A range command covers at most CHUNK_BYTES (1024): `cmd_hi - cmd_lo <= CHUNK_BYTES - LINE_BYTES`.
- R3: A chunk never continues past the end of the page holding its first line. The chunk end is the smallest of the request end, start plus CHUNK_BYTES, and `(start | (PAGE_BYTES-1)) + 1`.
- R4: For invalidate (`req_op` = 0) with an unaligned start, the first command is a line clean-invalidate (`cmd_op` = 0, `cmd_lo == cmd_hi`) of the line holding the start. The ranges then begin at the next line boundary.
- R5: For invalidate, a line clean-invalidate of the line holding `req_end` is emitted only when `req_end` is unaligned and the advanced start is still below `req_end`. The range end then drops to that line boundary. A request inside one line therefore yields one command.
- R6: For clean (`req_op` = 1) and flush (`req_op` = 2 or 3), the start is aligned down and the end is rounded up to a line boundary before splitting.
- R7: Flush emits a range clean (`cmd_op` = 1) followed by a range invalidate (`cmd_op` = 2) for each chunk. With `wt_mode` high, only the invalidate is emitted.
- R8: A clean request with `wt_mode` high emits no command and completes.
- R9: Commands are emitted in ascending address order: the leading edge line, then the chunks, then the trailing edge line.
- R10: `req_ready` is high only while idle. `done` is a one-cycle pulse in the cycle after the last command handshake, and `req_ready` rises in the cycle after `done`.
- R11: A range that is empty after alignment emits no command. `done` is then high in the cycle after the request is accepted.
- R12: While `cmd_valid` is high and `cmd_ready` low, the command stays valid and its fields do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken on this edge |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 or 3 flush |
| req_start | input | ADDR_W | First byte of the range |
| req_end | input | ADDR_W | One past the last byte of the range |
| wt_mode | input | 1 | Write-through override, sampled with the request |
| cmd_valid | output | 1 | Command offered to the engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_op | output | 2 | 0 line clean-invalidate, 1 range clean, 2 range invalidate |
| cmd_lo | output | ADDR_W | First line address, inclusive |
| cmd_hi | output | ADDR_W | Last line address, inclusive |
| done | output | 1 | Request finished, one-cycle pulse |

## Verification
A corrupted chunk cursor or limit appears at the port in the next offered command. The command shows a wrong `cmd_lo`, a span that breaks the size or page bound, or an extra or missing chunk before `done`. A stuck edge-line flag shows up either as a missing line command at the very start of the request or as a second line command after the last chunk. A wrong flush phase shows up as two cleans or two invalidates with the same `cmd_lo`, within one handshake. Loss of the busy state shows up as `done` arriving early or late relative to the last handshake, or as `req_ready` rising while commands remain.

// File: rtl/range_splitter.sv
module range_splitter #(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 32,
  parameter int CHUNK_BYTES = 1024,
  parameter int PAGE_BYTES  = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_start,
  input  logic [ADDR_W-1:0] req_end,
  input  logic              wt_mode,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_lo,
  output logic [ADDR_W-1:0] cmd_hi,
  output logic              done
);
  localparam int LSB = $clog2(LINE_BYTES);
  localparam int W   = ADDR_W + 1;
  localparam logic [W-1:0] LINE_W  = W'(LINE_BYTES);
  localparam logic [W-1:0] CHUNK_W = W'(CHUNK_BYTES);
  localparam logic [W-1:0] PG_MASK = W'(PAGE_BYTES - 1);
  localparam logic [1:0] OP_LINE = 2'd0, OP_CLN = 2'd1, OP_INV = 2'd2;

  logic              busy, head_p, tail_p, phase, wt_r;
  logic [1:0]        op_r;
  logic [W-1:0]      cur, lim, head_a, tail_a;

  wire [W-1:0] s_in  = {1'b0, req_start};
  wire [W-1:0] e_in  = {1'b0, req_end};
  wire         off_s = |req_start[LSB-1:0];
  wire         off_e = |req_end[LSB-1:0];
  wire [W-1:0] s_dn  = {s_in[W-1:LSB], {LSB{1'b0}}};
  wire [W-1:0] e_dn  = {e_in[W-1:LSB], {LSB{1'b0}}};
  wire [W-1:0] s_up  = s_dn + (off_s ? LINE_W : '0);
  wire [W-1:0] e_up  = e_dn + (off_e ? LINE_W : '0);
  wire         is_inv = (req_op == 2'd0);
  wire         is_cln = (req_op == 2'd1);
  wire         tail_take = is_inv && off_e && (s_up < e_in);
  wire [W-1:0] new_cur = is_inv ? s_up : s_dn;
  wire [W-1:0] new_lim = is_inv ? (tail_take ? e_dn : e_in)
                       : (is_cln && wt_mode) ? s_dn : e_up;

  wire [W-1:0] pg_end = (cur | PG_MASK) + LINE_W - LINE_W + W'(1);
  wire [W-1:0] cap    = cur + CHUNK_W;
  wire [W-1:0] lim_c  = (cap < lim) ? cap : lim;
  wire [W-1:0] nxt    = (pg_end < lim_c) ? pg_end : lim_c;

  wire range_p  = cur < lim;
  wire in_range = busy && !head_p && range_p;
  wire flush_r  = op_r[1];
  wire two_step = flush_r && !wt_r && !phase;
  wire [1:0] range_op = (op_r == 2'd1 || two_step) ? OP_CLN : OP_INV;
  wire [W-1:0] lo_w = head_p ? head_a : in_range ? cur : tail_a;
  wire [W-1:0] hi_w = head_p ? head_a : in_range ? (nxt - LINE_W) : tail_a;

  assign req_ready = !busy;
  assign cmd_valid = busy && (head_p || range_p || tail_p);
  assign done      = busy && !cmd_valid;
  assign cmd_op    = in_range ? range_op : OP_LINE;
  assign cmd_lo    = lo_w[ADDR_W-1:0];
  assign cmd_hi    = hi_w[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      head_p <= 1'b0;
      tail_p <= 1'b0;
      phase  <= 1'b0;
      wt_r   <= 1'b0;
      op_r   <= 2'd0;
      cur    <= '0;
      lim    <= '0;
      head_a <= '0;
      tail_a <= '0;
    end else if (req_valid && req_ready) begin
      busy   <= 1'b1;
      head_p <= is_inv && off_s;
      head_a <= s_dn;
      tail_p <= tail_take;
      tail_a <= e_dn;
      cur    <= new_cur;
      lim    <= new_lim;
      op_r   <= req_op;
      wt_r   <= wt_mode;
      phase  <= 1'b0;
    end else if (done) begin
      busy <= 1'b0;
    end else if (cmd_valid && cmd_ready) begin
      if (head_p) begin
        head_p <= 1'b0;
      end else if (range_p) begin
        if (two_step) begin
          phase <= 1'b1;
        end else begin
          cur   <= nxt;
          phase <= 1'b0;
        end
      end else begin
        tail_p <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/range_splitter_chk.sv
module range_splitter_chk #(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 32,
  parameter int CHUNK_BYTES = 1024,
  parameter int PAGE_BYTES  = 4096
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_lo,
  input logic [ADDR_W-1:0] cmd_hi,
  input logic              done
);
  localparam int LSB    = $clog2(LINE_BYTES);
  localparam int PG_LSB = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] SPAN_MAX = ADDR_W'(CHUNK_BYTES - LINE_BYTES);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_lo) && $stable(cmd_hi)); // R12
  AST_PAGE_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_lo[ADDR_W-1:PG_LSB] == cmd_hi[ADDR_W-1:PG_LSB]); // R3
  AST_CHUNK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_hi - cmd_lo) <= SPAN_MAX); // R2
  AST_LINE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_lo[LSB-1:0] == '0 && cmd_hi[LSB-1:0] == '0 && cmd_hi >= cmd_lo); // R1
  AST_SINGLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd0 |-> cmd_lo == cmd_hi); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready); // R10
  AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready && !done); // R10
  AST_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid || cmd_lo >= $past(cmd_lo)); // R9
endmodule

bind range_splitter range_splitter_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .CHUNK_BYTES(CHUNK_BYTES), .PAGE_BYTES(PAGE_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .done(done)
);

// File: tb/sim_range_splitter.sv
module sim_range_splitter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [31:0] req_start = '0;
  logic [31:0] req_end = '0;
  logic        wt_mode = 1'b0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [1:0]  cmd_op;
  logic [31:0] cmd_lo, cmd_hi;
  logic        done;

  int errors = 0;
  int checks = 0;

  logic [1:0]  exp_op [0:63];
  logic [31:0] exp_lo [0:63];
  logic [31:0] exp_hi [0:63];
  int exp_n;

  always #4 clk = ~clk;

  range_splitter u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_start(req_start), .req_end(req_end), .wt_mode(wt_mode),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] op, input longint lo, input longint hi);
    if (exp_n < 64) begin
      exp_op[exp_n] = op;
      exp_lo[exp_n] = lo[31:0];
      exp_hi[exp_n] = hi[31:0];
    end
    exp_n++;
  endtask

  task automatic add_chunks(input longint s, input longint e, input bit cln, input bit inv);
    longint re;
    while (s < e) begin
      re = e;
      if (s + 1024 < re) re = s + 1024;
      if ((s | 4095) + 1 < re) re = (s | 4095) + 1;
      if (cln) push(2'd1, s, re - 32);
      if (inv) push(2'd2, s, re - 32);
      s = re;
    end
  endtask

  task automatic model(input int op, input longint s, input longint e, input bit wt);
    longint t;
    bit have_t;
    exp_n = 0;
    have_t = 0;
    t = 0;
    if (op == 0) begin
      if (s % 32 != 0) begin
        push(2'd0, s & ~longint'(31), s & ~longint'(31));
        s = (s | 31) + 1;
      end
      if (s < e && e % 32 != 0) begin
        have_t = 1;
        t = e & ~longint'(31);
        e = t;
      end
      add_chunks(s, e, 1'b0, 1'b1);
      if (have_t) push(2'd0, t, t);
    end else begin
      s = s & ~longint'(31);
      e = (e + 31) & ~longint'(31);
      add_chunks(s, e, !wt, op != 1);
    end
  endtask

  task automatic run_req(input string tag, input int op, input longint s, input longint e,
                         input bit wt, input bit stall_en);
    int idx;
    bit prev_final, got_done, hold_valid, stall;
    logic [1:0] h_op;
    logic [31:0] h_lo, h_hi;
    model(op, s, e, wt);
    @(negedge clk);
    chk(req_ready === 1'b1, "R10", "req_ready idle before request", req_ready, 1);
    req_op = op[1:0];
    req_start = s[31:0];
    req_end = e[31:0];
    wt_mode = wt;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    idx = 0;
    prev_final = (exp_n == 0);
    got_done = 0;
    hold_valid = 0;
    h_op = '0; h_lo = '0; h_hi = '0;
    for (int c = 0; c < 4000 && !got_done; c++) begin
      if (c > 0) @(negedge clk);
      if (done !== prev_final)
        chk(1'b0, tag, "R10 done timing", done, prev_final);
      if (hold_valid)
        chk(cmd_valid === 1'b1 && cmd_op === h_op && cmd_lo === h_lo && cmd_hi === h_hi,
            "R12", "held command", {cmd_op, cmd_lo}, {h_op, h_lo});
      if (done) begin
        got_done = 1;
        chk(prev_final, tag, "R10 done after last handshake", done, 1);
      end else begin
        if (req_ready) chk(1'b0, "R10", "req_ready while busy", req_ready, 0);
        stall = stall_en && (c % 3 == 1);
        cmd_ready = !stall;
        prev_final = 0;
        hold_valid = 0;
        if (cmd_valid) begin
          if (stall) begin
            hold_valid = 1;
            h_op = cmd_op; h_lo = cmd_lo; h_hi = cmd_hi;
          end else if (idx >= exp_n || idx >= 64) begin
            chk(1'b0, tag, "R1 extra command lo", cmd_lo, 0);
            idx++;
          end else begin
            chk(cmd_op === exp_op[idx], tag, "R1 cmd_op", cmd_op, exp_op[idx]);
            chk(cmd_lo === exp_lo[idx], tag, "R1 cmd_lo", cmd_lo, exp_lo[idx]);
            chk(cmd_hi === exp_hi[idx], tag, "R1 cmd_hi", cmd_hi, exp_hi[idx]);
            idx++;
            prev_final = (idx == exp_n);
          end
        end
      end
    end
    cmd_ready = 1'b0;
    chk(got_done, tag, "R10 done seen", got_done, 1);
    chk(idx == exp_n, tag, "R9 command count", idx, exp_n);
    @(negedge clk);
    chk(req_ready === 1'b1, "R10", "req_ready after done", req_ready, 1);
  endtask

  task automatic t_reset();
    chk(req_ready === 1'b1, "R10", "reset req_ready", req_ready, 1);
    chk(cmd_valid === 1'b0, "R10", "reset cmd_valid", cmd_valid, 0);
    chk(done === 1'b0, "R10", "reset done", done, 0);
  endtask

  task automatic t_inv_edges();     run_req("R4 R5 R9", 0, 'h1010, 'h1050, 0, 0); endtask
  task automatic t_inv_same_line(); run_req("R5", 0, 'h2004, 'h2010, 0, 0); endtask
  task automatic t_inv_head_only(); run_req("R4", 0, 'h7008, 'h7040, 0, 1); endtask
  task automatic t_inv_large();     run_req("R1 R2 R3", 0, 'h0, 'h1800, 0, 1); endtask
  task automatic t_clean_page();    run_req("R3", 1, 'h0F00, 'h1100, 0, 0); endtask
  task automatic t_clean_round();   run_req("R6", 1, 'h3005, 'h3041, 0, 0); endtask
  task automatic t_flush();         run_req("R7 R12", 2, 'h0E00, 'h1200, 0, 1); endtask
  task automatic t_flush_wt();      run_req("R7", 3, 'h0E10, 'h11F0, 1, 0); endtask
  task automatic t_clean_wt();      run_req("R8", 1, 'h0, 'h800, 1, 0); endtask
  task automatic t_empty();
    run_req("R11", 0, 'h4000, 'h4000, 0, 0);
    run_req("R11", 1, 'h5000, 'h5000, 0, 0);
    run_req("R11", 2, 'h6000, 'h6000, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_inv_edges();
    t_inv_same_line();
    t_inv_head_only();
    t_inv_large();
    t_clean_page();
    t_clean_round();
    t_flush();
    t_flush_wt();
    t_clean_wt();
    t_empty();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule